// File: doc/BRIEF.md
# Sweep-Stepped Trace Multiplexer

This block lets a single-channel oscilloscope display up to eight logic signals at once, each on its own horizontal band of the screen. The scope's sweep or gate output drives a pulse input. On each rising edge of that pulse an internal lane index moves on by one. The lane index picks one of the logic inputs. On the next sweep the scope therefore draws a different signal.

The block drives a 4-bit code into an external resistor-ladder DAC, whose output feeds the scope's vertical input. The three lane-index bits form the upper part of the code and place each lane at its own base level. The live value of the selected input forms the lowest bit, so a logic high lifts the trace by one step above that base. A lane-limit input can shorten the rotation so that only the first few inputs take part.

Top module: `trace_stacker`

## Requirements
- R1: While `rst` is high at a clock edge, the lane index and `dac_code` are cleared to 0, and `dac_code` reads 0 on the cycle after reset is released.
- R2: The lane index advances by exactly one for each low-to-high transition of `sweep_in`. A pulse held high for many cycles counts once, and the index never changes without such a transition.
- R3: With the full lane count in effect, a sweep edge taken at lane 7 returns the index to lane 0.
- R4: `dac_code[3:1]` carries the lane index, with index bit 2 in code bit 3, bit 1 in code bit 2 and bit 0 in code bit 1.
- R5: `dac_code[0]` equals `sig_in[lane]` as sampled at the previous clock edge. The inputs of the other lanes have no effect on `dac_code`.
- R6: An index change appears on `dac_code` at the fourth rising clock edge after `sweep_in` goes high, counting the edge that first samples it high. The code changes only at clock edges.
- R7: A `chan_limit` value N from 1 to 7 makes the index wrap from N-1 to 0. With N = 1 the index stays at 0.
- R8: A `chan_limit` of 0, or of any value above 8, selects all eight lanes.
- R9: When `chan_limit` is lowered to or below the current index, the next sweep edge returns the index to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sweep_in | input | 1 | Asynchronous sweep pulse from the scope; its rising edge advances the lane |
| sig_in | input | 8 | Logic inputs, one per lane; bit i is lane i |
| chan_limit | input | 4 | Number of lanes in rotation; 0 or above 8 means eight |
| dac_code | output | 4 | Registered DAC word: lane index in bits 3:1, selected input level in bit 0 |

## Verification
The assertions assume that `sweep_in` is low while reset is active, so that reset release does not create an edge. They also assume that `chan_limit` and `sig_in` change only well away from clock edges. The stimulus drives every input at the falling clock edge. It keeps `sweep_in` low through each reset, and it holds each level of a sweep pulse for at least three cycles so that the two-flop synchronizer cannot miss an edge. A lane limit is changed only while `sweep_in` is low and settled, so each wrap point is taken with a stable limit.

// File: rtl/trace_pkg.sv
package trace_pkg;

    // Number of logic lanes and the widths derived from it
    parameter int unsigned TRACE_CH = 8;
    localparam int unsigned SEL_W   = $clog2(TRACE_CH);
    localparam int unsigned LIM_W   = SEL_W + 1;
    localparam int unsigned CODE_W  = SEL_W + 1;

    typedef logic [SEL_W-1:0] lane_t;
    typedef logic [LIM_W-1:0] limit_t;

    // DAC word: coarse offset from the lane, one fine step from the live bit
    typedef struct packed {
        lane_t lane;
        logic  level;
    } dac_word_t;

    // Effective rotation length: zero or out of range means all lanes
    function automatic limit_t eff_limit(input limit_t lim);
        if (lim == '0 || lim > limit_t'(TRACE_CH))
            return limit_t'(TRACE_CH);
        return lim;
    endfunction

    // Next lane given the current one and the requested limit
    function automatic lane_t step_lane(input lane_t cur, input limit_t lim);
        limit_t nxt;
        nxt = limit_t'(cur) + limit_t'(1);
        if (nxt >= eff_limit(lim))
            return '0;
        return nxt[SEL_W-1:0];
    endfunction

endpackage

// File: rtl/sweep_edge.sv
module sweep_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[0] <= 1'b0;
                    else     sync_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[g] <= 1'b0;
                    else     sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= sync_q[STAGES-1];
    end

    assign rise_o = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/lane_counter.sv
module lane_counter
    import trace_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   step_i,
    input  limit_t limit_i,
    output lane_t  lane_o
);
    lane_t lane_q;

    always_ff @(posedge clk) begin
        if (rst)         lane_q <= '0;
        else if (step_i) lane_q <= step_lane(lane_q, limit_i);
    end

    assign lane_o = lane_q;

endmodule

// File: rtl/trace_encoder.sv
module trace_encoder
    import trace_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  lane_t               lane_i,
    input  logic [TRACE_CH-1:0] sig_i,
    output dac_word_t           code_o
);
    logic      picked;
    dac_word_t code_q;

    // 8:1 selection of the live input
    always_comb begin
        picked = 1'b0;
        for (int i = 0; i < TRACE_CH; i++) begin
            if (lane_i == lane_t'(i)) picked = sig_i[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
        end else begin
            code_q.lane  <= lane_i;
            code_q.level <= picked;
        end
    end

    assign code_o = code_q;

endmodule

// File: rtl/trace_stacker.sv
module trace_stacker
    import trace_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sweep_in,
    input  logic [TRACE_CH-1:0] sig_in,
    input  logic [LIM_W-1:0]    chan_limit,
    output logic [CODE_W-1:0]   dac_code
);
    logic      sweep_rise;
    lane_t     cur_lane;
    dac_word_t word;

    sweep_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .async_in (sweep_in),
        .rise_o   (sweep_rise)
    );

    lane_counter u_count (
        .clk     (clk),
        .rst     (rst),
        .step_i  (sweep_rise),
        .limit_i (chan_limit),
        .lane_o  (cur_lane)
    );

    trace_encoder u_enc (
        .clk    (clk),
        .rst    (rst),
        .lane_i (cur_lane),
        .sig_i  (sig_in),
        .code_o (word)
    );

    assign dac_code = word;

endmodule

// File: rtl/trace_stacker_chk.sv
module trace_stacker_chk
    import trace_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                step,
    input lane_t               lane,
    input logic [TRACE_CH-1:0] sig_in,
    input logic [CODE_W-1:0]   dac_code
);
    // R1: code is clear on the cycle after reset
    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> dac_code == '0);

    // R2: the lane moves only on a detected sweep edge
    assert_hold_without_edge_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(step)) |-> $stable(lane));

    // R3: an edge taken at the top lane always returns to zero
    assert_wrap_top_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(step) && $past(lane) == lane_t'(TRACE_CH - 1)) |-> lane == '0);

    // R4: upper code bits follow the lane one cycle later
    assert_offset_bits_R4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> dac_code[CODE_W-1:1] == $past(lane));

    // R5: lowest code bit is the selected input, registered
    assert_live_bit_R5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> dac_code[0] == $past(sig_in[lane]));

endmodule

bind trace_stacker trace_stacker_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .step     (sweep_rise),
    .lane     (cur_lane),
    .sig_in   (sig_in),
    .dac_code (dac_code)
);

// File: tb/trace_stacker_test.sv
`timescale 1ns/1ps
module trace_stacker_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sweep_in = 1'b0;
    logic [7:0] sig_in = 8'h00;
    logic [3:0] chan_limit = 4'd0;
    logic [3:0] dac_code;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    trace_stacker uut (
        .clk        (clk),
        .rst        (rst),
        .sweep_in   (sweep_in),
        .sig_in     (sig_in),
        .chan_limit (chan_limit),
        .dac_code   (dac_code)
    );

    // Vector fields: limit[23:20] inputs[19:12] pulses[11:8] unused[7:4] expected code[3:0]
    localparam int NV = 15;
    localparam logic [23:0] VEC [0:NV-1] = '{
        {4'd0, 8'h00, 4'd1, 4'd0, 4'd2},   // R4 lane 1
        {4'd0, 8'h02, 4'd0, 4'd0, 4'd3},   // R5 live bit of lane 1
        {4'd0, 8'hFD, 4'd2, 4'd0, 4'd7},   // R2 lane 3
        {4'd0, 8'h08, 4'd4, 4'd0, 4'd14},  // R4 lane 7, bit low
        {4'd0, 8'h80, 4'd0, 4'd0, 4'd15},  // R5 lane 7, bit high
        {4'd0, 8'h01, 4'd1, 4'd0, 4'd1},   // R3 wrap 7 to 0
        {4'd3, 8'h00, 4'd2, 4'd0, 4'd4},   // R7 lane 2 with limit 3
        {4'd3, 8'h04, 4'd1, 4'd0, 4'd0},   // R7 wrap at 2
        {4'd3, 8'h00, 4'd3, 4'd0, 4'd0},   // R7 full short loop
        {4'd9, 8'hAA, 4'd5, 4'd0, 4'd11},  // R8 out of range = eight lanes
        {4'd0, 8'hAA, 4'd3, 4'd0, 4'd0},   // R8 zero = eight lanes, wraps
        {4'd0, 8'h00, 4'd6, 4'd0, 4'd12},  // R2 lane 6
        {4'd2, 8'h00, 4'd1, 4'd0, 4'd0},   // R9 lowered limit returns to 0
        {4'd1, 8'hFF, 4'd3, 4'd0, 4'd1},   // R7 limit 1 stays at lane 0
        {4'd0, 8'hFF, 4'd1, 4'd0, 4'd3}    // R8 back to full rotation
    };

    function automatic string vec_req(input int i);
        case (i)
            0, 3:        return "R4";
            1, 4:        return "R5";
            2, 11:       return "R2";
            5:           return "R3";
            6, 7, 8, 13: return "R7";
            12:          return "R9";
            default:     return "R8";
        endcase
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: dac_code actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse();
        sweep_in = 1'b1;
        cycles(3);
        sweep_in = 1'b0;
        cycles(3);
    endtask

    initial begin
        cycles(4);
        check("R1", dac_code, 4'd0);
        rst = 1'b0;
        cycles(1);
        check("R1", dac_code, 4'd0);

        for (int i = 0; i < NV; i++) begin
            chan_limit = VEC[i][23:20];
            sig_in     = VEC[i][19:12];
            for (int p = 0; p < int'(VEC[i][11:8]); p++) pulse();
            cycles(3);
            check(vec_req(i), dac_code, VEC[i][3:0]);
        end
        // lane is now 1, full rotation

        // R5: other lanes have no effect
        sig_in = 8'hFD;
        cycles(1);
        check("R5", dac_code, 4'd2);
        sig_in = 8'h02;
        cycles(1);
        check("R5", dac_code, 4'd3);

        // R6: exact latency of a lane change (lane 1 -> 2)
        sig_in   = 8'h00;
        sweep_in = 1'b1;
        cycles(3);
        check("R6", dac_code, 4'd2);
        cycles(1);
        check("R6", dac_code, 4'd4);
        // R2: held pulse counts once
        cycles(20);
        check("R2", dac_code, 4'd4);
        sweep_in = 1'b0;
        cycles(6);
        check("R2", dac_code, 4'd4);

        // R1: reset in mid-run
        rst = 1'b1;
        cycles(2);
        rst = 1'b0;
        cycles(1);
        check("R1", dac_code, 4'd0);
        pulse();
        cycles(2);
        check("R1", dac_code, 4'd2);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule